// File: doc/BRIEF.md
# TDM Timeslot BER Tester

This block runs a bit-error-rate test over a serial time-division-multiplexed link. A shared pseudo-random generator feeds the bits of every transmit timeslot whose channel entry is set to the pattern mode. It runs whenever the output drive enable is high, and there is no separate start control. A checker watches one receive timeslot, chosen by stream and channel. It predicts each arriving bit from the bits it has already received and counts every mismatch in a saturating counter.

Software drives the test through a small word-wide register port. It marks one transmit channel as the pattern carrier and waits for the loop delay. It then chooses the receive slot, enables the checker, and clears the counter once the checker has aligned. There is no lock flag. Errors counted before alignment stay in the counter until software clears it.

Timing comes from a bit clock and a frame pulse. Each frame holds NCH channels of BPC bits per stream, and every stream is aligned to the same frame. Every timeslot not in pattern mode is left undriven.

Top module: `tdmber_top`

## Requirements
- R1: After reset, every channel entry reads back 0x0000 (undriven mode), `tx_drive` is all zero, the control register at 0x000 reads 0 and the error count at 0x002 reads 0.
- R2: The pattern follows x^15+x^14+1, with all ones in the first 15 output bits. The generator moves on one bit in each bit time in which at least one stream's current channel is in pattern mode and `drive_en` is high. Every such stream drives that bit, and `tx_drive` is high for it. In all other bit times `tx_drive` is low and `tx_data` is 1.
- R3: A channel entry sits at address 0x200 + stream*NCH + channel. Its mode field is bits [15:13], and 3'b111 (0xE000) selects the pattern. Only the mode field is stored, so reading back 0x1234 returns 0x0000.
- R4: A bit time in which `frame_pulse` is high is bit 0 of channel 0, and this restarts the frame at any point. Channel c covers bit times 8c to 8c+7 after the pulse, most significant bit first.
- R5: The receive select register sits at 0x001. Bits [15:8] hold the stream and bits [7:0] hold the channel, so 0x0205 selects stream 2, channel 5. It reads back as written.
- R6: The checker compares and counts only while bit 7 of the control register is 1. While that bit is 0, the error count holds its value.
- R7: Each checked bit is predicted as the XOR of the bits received 15 and 14 checked positions earlier. An error-free pattern therefore counts nothing once the checker has aligned, and one flipped bit adds exactly 3 to the count.
- R8: While bit 8 of the control register is 1, the error count is held at 0. Counting resumes after software writes the bit back to 0.
- R9: The error count at 0x002 is ERR_W bits wide (16 by default). It rises by one for each mismatch and stops at its all-ones value.
- R10: If two transmit channels of one stream are both in pattern mode, the sequence is split between them, and a checker on one of those channels counts errors.
- R11: Errors counted before the checker aligns are kept, and no later error-free traffic removes them. Only the clear bit returns the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | Marks bit 0 of channel 0 |
| drive_en | input | 1 | Output drive enable; also lets the generator run |
| rx_data | input | NS | Serial receive data, one bit per stream |
| tx_data | output | NS | Serial transmit data, one bit per stream |
| tx_drive | output | NS | High when the stream drives its current bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from the address |

## Verification
Two conditions are hard to reach from the ports. One is a single corrupted bit at a known position inside the selected timeslot. The other is a counter that has reached its ceiling. The bench anchors its cycle count with the frame pulse and flips the looped-back receive line in exactly one bit time of the checked channel. It then expects a rise of three. To reach saturation in few cycles, it turns off drive enable so the line stays at constant ones. The checker's prediction is then wrong on every checked bit, and the bench builds the design with a narrower counter.

// File: rtl/tdmber_pkg.sv
package tdmber_pkg;

  // Generator / checker register length, fixed by the x^15 + x^14 + 1 polynomial
  localparam int PRBS_W = 15;

  // Channel mode codes held in bits [15:13] of a channel entry
  localparam logic [2:0] MODE_UNDRIVEN = 3'b000;
  localparam logic [2:0] MODE_PATTERN  = 3'b111;

  // Register word addresses
  localparam int CTRL_ADDR  = 'h000;
  localparam int RXSEL_ADDR = 'h001;
  localparam int ERRS_ADDR  = 'h002;
  localparam int TBL_BASE   = 'h200;

  // Control bit positions
  localparam int CTRL_RXEN_BIT = 7;
  localparam int CTRL_CLR_BIT  = 8;

  // Oldest bit leaves at the top, the new bit enters at the bottom
  function automatic logic [PRBS_W-1:0] prbs_advance(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction

  // Expected next bit given the last PRBS_W received bits (newest at bit 0)
  function automatic logic prbs_expect(input logic [PRBS_W-1:0] h);
    return h[PRBS_W-1] ^ h[PRBS_W-2];
  endfunction

endpackage

// File: rtl/tdmber_slot_timer.sv
module tdmber_slot_timer #(
  parameter int NCH = 32,
  parameter int BPC = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frame_pulse,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cur_chan
);
  localparam int FRAME_BITS = NCH * BPC;
  localparam int POS_W      = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             frame_end;

  // The pulse cycle itself is bit 0 of channel 0
  assign cur_pos   = frame_pulse ? '0 : pos_q;
  assign frame_end = (cur_pos == POS_W'(FRAME_BITS - 1));
  assign cur_chan  = CH_W'(cur_pos / POS_W'(BPC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_q <= '0;
    else if (frame_end) pos_q <= '0;
    else                pos_q <= cur_pos + 1'b1;
  end
endmodule

// File: rtl/tdmber_regs.sv
module tdmber_regs
  import tdmber_pkg::*;
#(
  parameter int NS    = 4,
  parameter int NCH   = 32,
  parameter int ERR_W = 16,
  parameter int AW    = 10
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_wr,
  input  logic [AW-1:0]                         reg_addr,
  input  logic [15:0]                           reg_wdata,
  output logic [15:0]                           reg_rdata,
  input  logic [ERR_W-1:0]                      err_cnt,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cur_chan,
  output logic [NS-1:0]                         pattern_slot,
  output logic                                  rx_en,
  output logic                                  cnt_clr,
  output logic [((NS > 1) ? $clog2(NS) : 1)-1:0]   sel_stream,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] sel_chan
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SS_W  = (NS > 1) ? $clog2(NS) : 1;
  localparam int TBL_N = NS * NCH;
  localparam int IDX_W = (TBL_N > 1) ? $clog2(TBL_N) : 1;

  logic [2:0]       mode_q [TBL_N];
  logic             hit_ctrl, hit_sel, hit_errs, hit_tbl;
  logic [AW-1:0]    tbl_off;
  logic [IDX_W-1:0] tbl_idx;
  logic             unused_wdata;

  assign hit_ctrl = (reg_addr == AW'(CTRL_ADDR));
  assign hit_sel  = (reg_addr == AW'(RXSEL_ADDR));
  assign hit_errs = (reg_addr == AW'(ERRS_ADDR));
  assign hit_tbl  = (reg_addr >= AW'(TBL_BASE)) && (reg_addr < AW'(TBL_BASE + TBL_N));
  assign tbl_off  = reg_addr - AW'(TBL_BASE);
  assign tbl_idx  = tbl_off[IDX_W-1:0];
  assign unused_wdata = ^{reg_wdata[6:0], reg_wdata[12:9]};

  // Control and receive select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en      <= 1'b0;
      cnt_clr    <= 1'b0;
      sel_stream <= '0;
      sel_chan   <= '0;
    end else if (reg_wr) begin
      if (hit_ctrl) begin
        rx_en   <= reg_wdata[CTRL_RXEN_BIT];
        cnt_clr <= reg_wdata[CTRL_CLR_BIT];
      end
      if (hit_sel) begin
        sel_stream <= reg_wdata[8 +: SS_W];
        sel_chan   <= reg_wdata[0 +: CH_W];
      end
    end
  end

  // Channel mode table: only the mode field is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_N; i++) mode_q[i] <= MODE_UNDRIVEN;
    end else if (reg_wr && hit_tbl) begin
      mode_q[tbl_idx] <= reg_wdata[15:13];
    end
  end

  // Per-stream lookup of the channel now on the line
  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic [IDX_W-1:0] row;
    assign row             = IDX_W'(s * NCH) + IDX_W'(cur_chan);
    assign pattern_slot[s] = (mode_q[row] == MODE_PATTERN);
  end

  // Read-back
  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[CTRL_RXEN_BIT] = rx_en;
      reg_rdata[CTRL_CLR_BIT]  = cnt_clr;
    end else if (hit_sel) begin
      reg_rdata[8 +: SS_W] = sel_stream;
      reg_rdata[0 +: CH_W] = sel_chan;
    end else if (hit_errs) begin
      reg_rdata[ERR_W-1:0] = err_cnt;
    end else if (hit_tbl) begin
      reg_rdata[15:13] = mode_q[tbl_idx];
    end
  end
endmodule

// File: rtl/tdmber_prbs_gen.sv
module tdmber_prbs_gen
  import tdmber_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic out_bit
);
  logic [PRBS_W-1:0] state_q;

  assign out_bit = state_q[PRBS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '1;
    else if (step) state_q <= prbs_advance(state_q);
  end
endmodule

// File: rtl/tdmber_checker.sv
module tdmber_checker
  import tdmber_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             rx_bit,
  input  logic             clr,
  output logic             miss,
  output logic [ERR_W-1:0] err_cnt
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic [PRBS_W-1:0] hist_q;

  // Self-synchronising: the history is made of received bits only
  assign miss = sample && (rx_bit != prbs_expect(hist_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q <= '0;
    else if (sample) hist_q <= {hist_q[PRBS_W-2:0], rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            err_cnt <= '0;
    else if (clr)                          err_cnt <= '0;
    else if (miss && (err_cnt != CNT_MAX)) err_cnt <= err_cnt + 1'b1;
  end
endmodule

// File: rtl/tdmber_top.sv
module tdmber_top
  import tdmber_pkg::*;
#(
  parameter int NS    = 4,
  parameter int NCH   = 32,
  parameter int BPC   = 8,
  parameter int ERR_W = 16,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic          drive_en,
  input  logic [NS-1:0] rx_data,
  output logic [NS-1:0] tx_data,
  output logic [NS-1:0] tx_drive,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SS_W = (NS > 1) ? $clog2(NS) : 1;

  // Named internal events
  logic [CH_W-1:0]  cur_chan;
  logic [NS-1:0]    pattern_slot;
  logic             rx_en;
  logic             cnt_clr;
  logic [SS_W-1:0]  sel_stream;
  logic [CH_W-1:0]  sel_chan;
  logic             gen_step;
  logic             gen_bit;
  logic             chk_sample;
  logic             chk_bit;
  logic             chk_miss;
  logic [ERR_W-1:0] err_cnt;

  tdmber_slot_timer #(.NCH(NCH), .BPC(BPC)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .cur_chan(cur_chan)
  );

  tdmber_regs #(.NS(NS), .NCH(NCH), .ERR_W(ERR_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_cnt(err_cnt), .cur_chan(cur_chan), .pattern_slot(pattern_slot),
    .rx_en(rx_en), .cnt_clr(cnt_clr), .sel_stream(sel_stream), .sel_chan(sel_chan)
  );

  // One sequence shared by every pattern-mode slot
  assign tx_drive = pattern_slot & {NS{drive_en}};
  assign gen_step = |tx_drive;

  tdmber_prbs_gen u_gen (
    .clk(clk), .rst_n(rst_n), .step(gen_step), .out_bit(gen_bit)
  );

  for (genvar s = 0; s < NS; s++) begin : g_tx
    assign tx_data[s] = tx_drive[s] ? gen_bit : 1'b1;
  end

  assign chk_sample = rx_en && (cur_chan == sel_chan);
  assign chk_bit    = rx_data[sel_stream];

  tdmber_checker #(.ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample(chk_sample), .rx_bit(chk_bit),
    .clr(cnt_clr), .miss(chk_miss), .err_cnt(err_cnt)
  );
endmodule

// File: rtl/tdmber_sva.sv
module tdmber_sva #(
  parameter int NS    = 4,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drive_en,
  input logic [NS-1:0]    tx_drive,
  input logic             rx_en,
  input logic             cnt_clr,
  input logic             chk_miss,
  input logic [ERR_W-1:0] err_cnt
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  // R2
  drive_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_drive) |-> drive_en);

  // R6
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !cnt_clr) |=> $stable(err_cnt));

  // R8
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (err_cnt == '0));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1)));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && (err_cnt == CNT_MAX)) |=> (err_cnt == CNT_MAX));

  // R7
  count_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !chk_miss) |=> $stable(err_cnt));
endmodule

bind tdmber_top tdmber_sva #(.NS(NS), .ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .tx_drive(tx_drive),
  .rx_en(rx_en), .cnt_clr(cnt_clr), .chk_miss(chk_miss), .err_cnt(err_cnt)
);

// File: tb/tdmber_top_test.sv
module tdmber_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int NCH  = 32;
  localparam int EW   = 10;
  localparam int FBITS = NCH * 8;
  localparam int CMAX = (1 << EW) - 1;
  localparam logic [9:0] A_CTRL = 10'h000;
  localparam logic [9:0] A_SEL  = 10'h001;
  localparam logic [9:0] A_CNT  = 10'h002;
  localparam logic [9:0] A_TBL  = 10'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_pulse = 1'b0;
  logic drive_en = 1'b0;
  logic [NS-1:0] rx_data, tx_data, tx_drive;
  logic [NS-1:0] rx_flip = '0;
  logic reg_wr = 1'b0;
  logic [9:0] reg_addr = A_CNT;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Loopback: every receive stream sees transmit stream 0
  assign rx_data = {NS{tx_data[0]}} ^ rx_flip;

  tdmber_top #(.NS(NS), .NCH(NCH), .BPC(8), .ERR_W(EW), .AW(10)) uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .drive_en(drive_en),
    .rx_data(rx_data), .tx_data(tx_data), .tx_drive(tx_drive),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct packed {
    logic [NS-1:0] drv;
    logic [NS-1:0] dat;
    logic          cv;
    logic [EW-1:0] cnt;
  } item_t;
  item_t sbq[$];

  bit       mq[$];        // upcoming pattern bits, front first
  bit       mh[$];        // last 15 checked bits, oldest first
  logic [2:0] m_mode [NS*NCH];
  bit       m_en, m_clr;
  int       m_sst, m_sch, m_pos, m_cnt;
  int       cur, ch;
  item_t    it;
  bit       anyd, rb;

  always begin
    @(negedge clk); #2;
    if (!rst_n) begin
      mq.delete(); mh.delete();
      for (int i = 0; i < 15; i++) begin mq.push_back(1'b1); mh.push_back(1'b0); end
      for (int i = 0; i < NS*NCH; i++) m_mode[i] = 3'b000;
      m_en = 0; m_clr = 0; m_sst = 0; m_sch = 0; m_pos = 0; m_cnt = 0;
      sbq.delete();
    end else begin
      cur = frame_pulse ? 0 : m_pos;
      ch  = cur / 8;
      anyd = 0;
      for (int s = 0; s < NS; s++) begin
        it.drv[s] = drive_en && (m_mode[s*NCH + ch] == 3'b111);
        it.dat[s] = it.drv[s] ? mq[0] : 1'b1;
        anyd |= it.drv[s];
      end
      if (anyd) begin mq.push_back(mq[0] ^ mq[1]); void'(mq.pop_front()); end
      it.cv  = (reg_addr == A_CNT);
      it.cnt = EW'(m_cnt);
      sbq.push_back(it);
      if (m_en && ch == m_sch) begin
        rb = rx_data[m_sst];
        if (!m_clr && rb != (mh[0] ^ mh[1]) && m_cnt < CMAX) m_cnt++;
        mh.push_back(rb); void'(mh.pop_front());
      end
      if (m_clr) m_cnt = 0;
      if (reg_wr) begin
        if (reg_addr == A_CTRL) begin m_en = reg_wdata[7]; m_clr = reg_wdata[8]; end
        if (reg_addr == A_SEL)  begin m_sst = reg_wdata[9:8]; m_sch = reg_wdata[4:0]; end
        if (reg_addr >= A_TBL && reg_addr < A_TBL + NS*NCH)
          m_mode[reg_addr - A_TBL] = reg_wdata[15:13];
      end
      m_pos = (cur == FBITS - 1) ? 0 : cur + 1;
    end
  end

  // Monitor: pops each expected item and compares with the ports
  item_t pit;
  always begin
    @(negedge clk); #3;
    if (sbq.size() > 0) begin
      pit = sbq.pop_front();
      check(tx_drive == pit.drv, "R2,R4 tx_drive", tx_drive, pit.drv);
      check(tx_data == pit.dat, "R2 tx_data", tx_data, pit.dat);
      if (pit.cv) check(reg_rdata[EW-1:0] == pit.cnt, "R7 R9 R11 count", reg_rdata, pit.cnt);
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = A_CNT;
  endtask

  task automatic rd(input logic [9:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #3;
    check(reg_rdata == 16'(exp), tag, reg_rdata, exp);
    reg_addr = A_CNT;
  endtask

  task automatic peek_cnt(output int v);
    @(negedge clk);
    reg_addr = A_CNT;
    #3;
    v = reg_rdata;
  endtask

  task automatic pulse_fp();
    @(negedge clk); frame_pulse = 1'b1;
    @(negedge clk); frame_pulse = 1'b0;
  endtask

  task automatic frames(input int n);
    repeat (n * FBITS) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 run did not end act=200000 exp=less");
    finish_run();
  end

  int c1, c2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, 0, "R1 ctrl after reset");
    rd(A_CNT, 0, "R1 count after reset");
    rd(A_TBL + 10'd1, 0, "R1 entry after reset");
    drive_en = 1'b1;
    @(negedge clk); #3;
    check(tx_drive == '0, "R1 no drive after reset", tx_drive, 0);

    // R3 mode field and storage
    wr(A_TBL + 10'd1, 16'hE000);
    rd(A_TBL + 10'd1, 16'hE000, "R3 pattern entry readback");
    wr(A_TBL + 10'd70, 16'h1234);
    rd(A_TBL + 10'd70, 16'h0000, "R3 only mode bits kept");

    pulse_fp();
    frames(3);

    // R5 select register
    wr(A_SEL, 16'h0205);
    rd(A_SEL, 16'h0205, "R5 select readback");
    wr(A_SEL, 16'h0201);
    rd(A_SEL, 16'h0201, "R5 select stream2 ch1");

    // R6 checker off: nothing counted
    frames(2);
    rd(A_CNT, 0, "R6 disabled checker counts nothing");

    // R11 pre-alignment errors stay
    wr(A_CTRL, 16'h0080);
    frames(3);
    peek_cnt(c1);
    frames(3);
    peek_cnt(c2);
    check(c1 == c2, "R11 pre-lock count kept", c2, c1);

    // R8 clear then release
    wr(A_CTRL, 16'h0180);
    rd(A_CTRL, 16'h0180, "R8 clear bit set");
    frames(1);
    rd(A_CNT, 0, "R8 held at zero");
    wr(A_CTRL, 16'h0080);
    frames(3);
    rd(A_CNT, 0, "R7 aligned clean pattern no errors");

    // R4 frame restart: channel 1 starts 8 bit times after the pulse
    @(negedge clk); frame_pulse = 1'b1; #3;
    check(tx_drive[0] == 1'b0, "R4 ch0 bit0 undriven", tx_drive[0], 0);
    @(negedge clk); frame_pulse = 1'b0;
    repeat (6) @(negedge clk);
    #3; check(tx_drive[0] == 1'b0, "R4 ch0 bit7 undriven", tx_drive[0], 0);
    @(negedge clk); #3;
    check(tx_drive[0] == 1'b1, "R4 ch1 bit0 driven", tx_drive[0], 1);
    frames(2);
    rd(A_CNT, 0, "R4 restart keeps pattern aligned");

    // R7 single flipped bit: channel 1 bit 3 of the next frame
    @(negedge clk); frame_pulse = 1'b1;
    @(negedge clk); frame_pulse = 1'b0;
    repeat (10) @(negedge clk);
    rx_flip[2] = 1'b1;
    @(negedge clk); rx_flip[2] = 1'b0;
    frames(4);
    rd(A_CNT, 3, "R7 one flip adds three");

    // R10 second pattern channel on the same stream
    wr(A_TBL + 10'd9, 16'hE000);
    frames(2);
    wr(A_CTRL, 16'h0180);
    wr(A_CTRL, 16'h0080);
    frames(6);
    peek_cnt(c1);
    check(c1 != 0, "R10 split pattern gives errors", c1, 1);
    wr(A_TBL + 10'd9, 16'h0000);

    // R9 saturation: undriven line stays at ones, every checked bit misses
    drive_en = 1'b0;
    @(negedge clk); #3;
    check(tx_data == '1, "R2 idle line is ones", tx_data, 15);
    wr(A_CTRL, 16'h0180);
    wr(A_CTRL, 16'h0080);
    frames(140);
    rd(A_CNT, CMAX, "R9 count saturates");

    // R6 disabling holds the count
    wr(A_CTRL, 16'h0000);
    frames(2);
    rd(A_CNT, CMAX, "R6 disabled count holds");

    // R8 clear with checker off
    wr(A_CTRL, 16'h0100);
    @(negedge clk);
    rd(A_CNT, 0, "R8 clear returns zero");
    wr(A_CTRL, 16'h0000);
    frames(1);
    rd(A_CNT, 0, "R8 stays zero after release");

    finish_run();
  end
endmodule